// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with Default Vector

This block collects eight interrupt request lines and drives one interrupt output toward a processor. It uses fixed priority, with line 0 the most urgent. When the processor answers with a one-cycle acknowledge strobe, the controller chooses the winner at that moment. It records the winner in an in-service register and returns a vector byte. The vector is a programmable base in the upper bits with the winning line number in the low three bits.

Each line can be masked. The controller runs either edge-triggered or level-triggered. In edge mode a rising edge is held in a per-line capture flop. That flop only counts while the line is still high and the line is unmasked. A request can therefore be raised, reach the processor as an interrupt, and then vanish before the acknowledge arrives. In that case the acknowledge returns a default vector carrying line number 7 and leaves the in-service register unchanged. Software can then compare in-service bit 7 with the vector and discard the stray entry.

Software drives the block through a small write port with three selects: mask, configuration and end-of-interrupt. It reads the in-service register on a dedicated output. Request inputs pass through a two-flop synchronizer before edge detection.

Top module: `prio_int_ctrl`

## Requirements
- R1: After reset, intOut, vecValid, vecOut and isrOut are all zero, every line is unmasked, edge mode is selected and the vector base is zero.
- R2: In edge mode a rising request that is still high and unmasked sets intOut. An acknowledge then sets exactly that line's bit in isrOut. Only an acknowledge can set an isrOut bit, and it sets at most one.
- R3: Among eligible requests the lowest line number wins the acknowledge.
- R4: A set isrOut bit stops its own line and all higher-numbered lines from raising intOut. A lower-numbered line can still raise intOut.
- R5: A write with cfgSel = 2 (end-of-interrupt, data ignored) clears the lowest-numbered set isrOut bit and no other bit. No isrOut bit clears without it.
- R6: In edge mode, a line that is captured and then drops low no longer counts. An acknowledge with nothing eligible returns the default vector {base, 3'b111} and leaves isrOut unchanged.
- R7: A write with cfgSel = 0 loads the mask, where bit i = 1 hides line i. A masked line cannot raise intOut or win an acknowledge. Its captured edge is kept, and it is served once unmasked.
- R8: The configuration word is written with cfgSel = 1. Low bits [2:0] = 3'b001 select level mode, and any other value selects edge mode. In level mode a line counts only while it is high, so a line still held high after end-of-interrupt requests again, and a line that drops stops counting.
- R9: In edge mode a winning acknowledge clears that line's captured edge. A line held high after its end-of-interrupt does not request again until it falls and rises once more.
- R10: vecValid pulses for exactly the one cycle after each acknowledge. vecOut then holds {cfgData[7:3] of the last configuration write, 3-bit line number}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Asynchronous request lines, active high |
| intOut | output | 1 | Registered interrupt request to the processor |
| ackStrobe | input | 1 | One-cycle interrupt acknowledge |
| vecOut | output | 8 | Vector byte returned for the last acknowledge |
| vecValid | output | 1 | Pulses the cycle after an acknowledge |
| cfgWe | input | 1 | Write strobe for the register port |
| cfgSel | input | 2 | 0 mask, 1 configuration, 2 end-of-interrupt |
| cfgData | input | 8 | Write data |
| isrOut | output | 8 | In-service register |

## Verification
The bench aims at the race between intOut and the acknowledge. It raises a request, lets it drop before acknowledging, and expects the default vector with isrOut untouched. A design that latched the winner when it raised intOut, or that set bit 7 for the default, would return a real vector or corrupt isrOut. Masking after capture checks that the edge survives and is served once unmasked, which a design that cleared the capture on mask would lose. End-of-interrupt ordering and the one-edge-one-service rule catch a wrong bit being cleared and a held-high line being served twice.

// File: rtl/intc_pkg.sv
package intc_pkg;

  // register-port select codes
  localparam logic [1:0] SEL_MASK = 2'd0;
  localparam logic [1:0] SEL_CFG  = 2'd1;
  localparam logic [1:0] SEL_EOI  = 2'd2;

  // strobes handed from control to datapath
  typedef struct packed {
    logic grant;     // acknowledge with an eligible winner
    logic spurious;  // acknowledge with nothing eligible
    logic eoi;       // clear highest-priority in-service bit
    logic loadMask;  // write mask register
    logic loadCfg;   // write base and trigger mode
  } intcStrobe_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int NUM_IRQ = 8,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic [NUM_IRQ-1:0] irqSync,
  output logic [NUM_IRQ-1:0] irqRise
);

  logic [NUM_IRQ-1:0] prevSync;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], irqIn[g]};
    end
    assign irqSync[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevSync <= '0;
    else       prevSync <= irqSync;
  end

  assign irqRise = irqSync & ~prevSync;

endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ackStrobe,
  input  logic        cfgWe,
  input  logic [1:0]  cfgSel,
  input  logic        anyAllowed,
  output intcStrobe_t strobes,
  output logic        vecValid
);

  always_comb begin
    strobes          = '0;
    strobes.grant    = ackStrobe & anyAllowed;
    strobes.spurious = ackStrobe & ~anyAllowed;
    strobes.eoi      = cfgWe & (cfgSel == SEL_EOI);
    strobes.loadMask = cfgWe & (cfgSel == SEL_MASK);
    strobes.loadCfg  = cfgWe & (cfgSel == SEL_CFG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) vecValid <= 1'b0;
    else       vecValid <= ackStrobe;
  end

endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  intcStrobe_t        strobes,
  input  logic [VEC_W-1:0]   cfgData,
  input  logic [NUM_IRQ-1:0] irqSync,
  input  logic [NUM_IRQ-1:0] irqRise,
  output logic               anyAllowed,
  output logic               intOut,
  output logic [VEC_W-1:0]   vecOut,
  output logic [NUM_IRQ-1:0] isrOut
);

  localparam int LVL_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = VEC_W - LVL_W;
  localparam logic [LVL_W-1:0] LEVEL_CODE = LVL_W'(1);
  localparam logic [LVL_W-1:0] DEFAULT_LVL = LVL_W'(NUM_IRQ - 1);

  logic [NUM_IRQ-1:0] maskReg;
  logic [NUM_IRQ-1:0] edgeLat;
  logic [NUM_IRQ-1:0] isrReg;
  logic [BASE_W-1:0]  baseReg;
  logic               levelMode;

  logic [NUM_IRQ-1:0] validReq;
  logic [NUM_IRQ-1:0] candReq;
  logic [NUM_IRQ-1:0] blockAcc;
  logic [NUM_IRQ-1:0] allowed;
  logic [NUM_IRQ-1:0] winOh;
  logic [NUM_IRQ-1:0] isrLow;
  logic [NUM_IRQ-1:0] setBits;
  logic [NUM_IRQ-1:0] clrBits;
  logic [LVL_W-1:0]   winIdx;

  // live request gating: edge capture only counts while the line is high
  assign validReq = levelMode ? irqSync : (edgeLat & irqSync);
  assign candReq  = validReq & ~maskReg;

  // cumulative in-service block: line i blocked if any isr bit j <= i set
  assign blockAcc[0] = isrReg[0];
  for (genvar g = 1; g < NUM_IRQ; g++) begin : gBlock
    assign blockAcc[g] = blockAcc[g-1] | isrReg[g];
  end

  assign allowed    = candReq & ~blockAcc;
  assign anyAllowed = |allowed;

  // lowest set bit wins
  assign winOh  = allowed & (~allowed + NUM_IRQ'(1));
  assign isrLow = isrReg & (~isrReg + NUM_IRQ'(1));

  always_comb begin
    winIdx = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (winOh[i]) winIdx = LVL_W'(i);
    end
  end

  assign setBits = strobes.grant ? winOh  : '0;
  assign clrBits = strobes.eoi   ? isrLow : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg   <= '0;
      baseReg   <= '0;
      levelMode <= 1'b0;
    end else begin
      if (strobes.loadMask) maskReg <= cfgData[NUM_IRQ-1:0];
      if (strobes.loadCfg) begin
        baseReg   <= cfgData[VEC_W-1:LVL_W];
        levelMode <= (cfgData[LVL_W-1:0] == LEVEL_CODE);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      edgeLat <= '0;
      isrReg  <= '0;
    end else begin
      edgeLat <= (edgeLat | irqRise) & ~setBits;
      isrReg  <= (isrReg & ~clrBits) | setBits;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vecOut <= '0;
      intOut <= 1'b0;
    end else begin
      intOut <= anyAllowed;
      if (strobes.grant)         vecOut <= {baseReg, winIdx};
      else if (strobes.spurious) vecOut <= {baseReg, DEFAULT_LVL};
    end
  end

  assign isrOut = isrReg;

endmodule

// File: rtl/prio_int_ctrl.sv
module prio_int_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  output logic               intOut,
  input  logic               ackStrobe,
  output logic [VEC_W-1:0]   vecOut,
  output logic               vecValid,
  input  logic               cfgWe,
  input  logic [1:0]         cfgSel,
  input  logic [VEC_W-1:0]   cfgData,
  output logic [NUM_IRQ-1:0] isrOut
);

  logic [NUM_IRQ-1:0] irqSync;
  logic [NUM_IRQ-1:0] irqRise;
  logic               anyAllowed;
  intcStrobe_t        strobes;

  intc_sync #(.NUM_IRQ(NUM_IRQ), .STAGES(SYNC_STAGES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .irqSync (irqSync),
    .irqRise (irqRise)
  );

  intc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .ackStrobe  (ackStrobe),
    .cfgWe      (cfgWe),
    .cfgSel     (cfgSel),
    .anyAllowed (anyAllowed),
    .strobes    (strobes),
    .vecValid   (vecValid)
  );

  intc_datapath #(.NUM_IRQ(NUM_IRQ), .VEC_W(VEC_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgData    (cfgData),
    .irqSync    (irqSync),
    .irqRise    (irqRise),
    .anyAllowed (anyAllowed),
    .intOut     (intOut),
    .vecOut     (vecOut),
    .isrOut     (isrOut)
  );

endmodule

// File: rtl/prio_int_ctrl_chk.sv
module prio_int_ctrl_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               intOut,
  input logic               ackStrobe,
  input logic               vecValid,
  input logic               cfgWe,
  input logic [1:0]         cfgSel,
  input logic [NUM_IRQ-1:0] isrOut
);

  AST_VALID_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> vecValid);  // R10

  AST_NO_VALID_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> !vecValid);  // R10

  AST_ISR_SET_ONLY_BY_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !ackStrobe |=> ((isrOut & ~$past(isrOut)) == '0));  // R2

  AST_ISR_SET_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> $onehot0(isrOut & ~$past(isrOut)));  // R2

  AST_EOI_CLEARS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWe && cfgSel == 2'd2 && !ackStrobe && isrOut != '0)
      |=> ($countones(isrOut) == $countones($past(isrOut)) - 1));  // R5

  AST_NO_CLEAR_WITHOUT_EOI: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWe && cfgSel == 2'd2) |=> ((~isrOut & $past(isrOut)) == '0));  // R5

  AST_TOP_ISR_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    $past(isrOut[0]) |-> !intOut);  // R4

endmodule

bind prio_int_ctrl prio_int_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .intOut    (intOut),
  .ackStrobe (ackStrobe),
  .vecValid  (vecValid),
  .cfgWe     (cfgWe),
  .cfgSel    (cfgSel),
  .isrOut    (isrOut)
);

// File: tb/tb_prio_int_ctrl.sv
`timescale 1ns/1ps
module tb_prio_int_ctrl;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] irqIn;
  logic       intOut;
  logic       ackStrobe;
  logic [7:0] vecOut;
  logic       vecValid;
  logic       cfgWe;
  logic [1:0] cfgSel;
  logic [7:0] cfgData;
  logic [7:0] isrOut;

  int  total = 0;
  int  fails = 0;
  bit  done  = 1'b0;

  always #2.5 clk = ~clk;

  prio_int_ctrl dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .intOut(intOut),
    .ackStrobe(ackStrobe), .vecOut(vecOut), .vecValid(vecValid),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData), .isrOut(isrOut)
  );

  // {spurious, level[2:0], request pattern[7:0]}
  localparam logic [11:0] VEC_TBL [8] = '{
    {1'b0, 3'd0, 8'h01},
    {1'b0, 3'd7, 8'h80},
    {1'b0, 3'd2, 8'h0C},
    {1'b0, 3'd4, 8'hF0},
    {1'b0, 3'd0, 8'hFF},
    {1'b1, 3'd7, 8'h00},
    {1'b0, 3'd5, 8'h60},
    {1'b0, 3'd1, 8'h82}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; irqIn = '0; ackStrobe = 1'b0;
    cfgWe = 1'b0; cfgSel = '0; cfgData = '0;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [7:0] data);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    waitCyc(1);
    cfgWe = 1'b0; cfgData = '0;
  endtask

  task automatic doAck();
    ackStrobe = 1'b1;
    waitCyc(1);
    ackStrobe = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 intOut", intOut, 0);
    check("R1 vecValid", vecValid, 0);
    check("R1 vecOut", vecOut, 0);
    check("R1 isrOut", isrOut, 0);
    irqIn = 8'h01;
    waitCyc(6);
    check("R1 unmasked edge request", intOut, 1);
    doAck();
    check("R1 zero base vector", vecOut, 8'h00);
    check("R1 isr after ack", isrOut, 8'h01);

    // R3 table of request patterns
    for (int k = 0; k < 8; k++) begin
      logic [11:0] e;
      e = VEC_TBL[k];
      doReset();
      writeReg(2'd1, 8'hA8);
      irqIn = e[7:0];
      waitCyc(6);
      check("R3 intOut", intOut, (e[7:0] != 0));
      doAck();
      check("R3 R10 vector", vecOut, 8'hA8 | e[10:8]);
      check("R3 R2 isr", isrOut, e[11] ? 8'h00 : (8'h01 << e[10:8]));
    end

    // R10 valid pulse width
    doReset();
    writeReg(2'd1, 8'hA8);
    ackStrobe = 1'b1;
    waitCyc(1);
    ackStrobe = 1'b0;
    check("R10 vecValid high", vecValid, 1);
    waitCyc(1);
    check("R10 vecValid low", vecValid, 0);

    // R4 and R5 nesting
    doReset();
    writeReg(2'd1, 8'hA8);
    irqIn = 8'h10;
    waitCyc(6);
    doAck();
    check("R4 isr line4", isrOut, 8'h10);
    irqIn = 8'h50;
    waitCyc(6);
    check("R4 lower blocked", intOut, 0);
    irqIn = 8'h54;
    waitCyc(6);
    check("R4 higher raises", intOut, 1);
    doAck();
    check("R4 nested vector", vecOut, 8'hAA);
    check("R4 nested isr", isrOut, 8'h14);
    writeReg(2'd2, 8'hFF);
    check("R5 first eoi", isrOut, 8'h10);
    waitCyc(2);
    check("R4 still blocked", intOut, 0);
    writeReg(2'd2, 8'h00);
    check("R5 second eoi", isrOut, 8'h00);
    waitCyc(2);
    check("R5 released line6", intOut, 1);
    doAck();
    check("R5 line6 vector", vecOut, 8'hAE);

    // R6 vanished request gives default vector
    doReset();
    writeReg(2'd1, 8'hA8);
    irqIn = 8'h08;
    waitCyc(6);
    check("R6 intOut raised", intOut, 1);
    irqIn = 8'h00;
    waitCyc(3);
    doAck();
    check("R6 default vector", vecOut, 8'hAF);
    check("R6 isr unchanged", isrOut, 8'h00);
    waitCyc(1);
    check("R6 intOut dropped", intOut, 0);

    // R7 mask keeps capture
    doReset();
    writeReg(2'd1, 8'hA8);
    writeReg(2'd0, 8'h02);
    irqIn = 8'h02;
    waitCyc(6);
    check("R7 masked no int", intOut, 0);
    doAck();
    check("R7 masked default vector", vecOut, 8'hAF);
    check("R7 masked isr", isrOut, 8'h00);
    writeReg(2'd0, 8'h00);
    waitCyc(3);
    check("R7 unmask raises", intOut, 1);
    doAck();
    check("R7 served vector", vecOut, 8'hA9);
    check("R7 served isr", isrOut, 8'h02);

    // R9 one edge one service
    writeReg(2'd2, 8'h00);
    waitCyc(3);
    check("R9 held line quiet", intOut, 0);
    check("R9 isr cleared", isrOut, 8'h00);
    irqIn = 8'h00;
    waitCyc(3);
    irqIn = 8'h02;
    waitCyc(6);
    check("R9 new edge raises", intOut, 1);

    // R8 level mode
    doReset();
    writeReg(2'd1, 8'hA9);
    irqIn = 8'h20;
    waitCyc(5);
    check("R8 level raises", intOut, 1);
    doAck();
    check("R8 level vector", vecOut, 8'hAD);
    writeReg(2'd2, 8'h00);
    waitCyc(3);
    check("R8 held level re-requests", intOut, 1);
    irqIn = 8'h00;
    waitCyc(4);
    check("R8 dropped level quiet", intOut, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule